// File: doc/BRIEF.md
# Periodic Row Refresh Request Generator

This block keeps a dynamic memory alive by telling the memory controller which row to refresh next, and when. Each cell in such a memory loses its charge over time, so every row has to be rewritten within a fixed retention period. The block computes that period in clock cycles from its parameters. It keeps a row pointer that advances after each completed refresh and wraps back to row 0 after the last row. It presents each refresh to the controller as a valid/ready request that carries the row number.

Two policies are available, chosen at run time through `mode_sel`. In spread mode, one refresh becomes due per slot, where a slot is the retention period divided by the number of rows. If the controller is slow, the owed refreshes build up in a saturating counter, so nothing is lost up to its depth. In burst mode, the whole array is requested back to back at the start of every retention window, and `busy` stays high while that pass is running. A change of policy takes effect only at a window boundary, and never while a burst pass is still unfinished.

Back-pressure rules: once `req_valid` rises, it stays high and `req_row` holds still until a clock edge at which `req_ready` is also high. That edge completes one refresh. The controller may hold `req_ready` high or low for as long as it likes. `mode_sel` and `busy` are plain level signals.

Top module: `row_refresh_sched`

## Requirements
- R1: A synchronous active-high `rst` clears `req_valid`, `busy`, the owed count and the burst pass, sets `req_row` to 0, and selects spread mode.
- R2: The slot length is SLOT = (CLK_MHZ*RETENTION_US)/ROWS cycles, and a window is SLOT*ROWS cycles. In spread mode one refresh becomes owed at the end of each slot, so the first request is visible SLOT cycles after reset is released and not before.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and `req_row` does not change. A refresh completes on a rising edge at which both are high.
- R4: Each completed refresh moves `req_row` up by one, and it wraps from ROWS-1 to 0, so rows are served in ascending order with no gaps.
- R5: Slots that expire while earlier refreshes are unserved are counted. `req_valid` stays high until all owed refreshes have completed. The count saturates at OWE_MAX (default 8), and slot ends beyond that are dropped.
- R6: In burst mode, each window boundary starts a pass of ROWS back-to-back requests. `busy` is high from the boundary until the last refresh of the pass completes. Slot ends raise no requests in burst mode.
- R7: `mode_sel` (1 = burst, 0 = spread) is adopted only at a window boundary. Between boundaries, the active policy does not change.
- R8: If a boundary arrives while a burst pass is unfinished, burst mode is kept whatever `mode_sel` says, and the pass restarts with a full ROWS requests. Entering burst mode discards spread refreshes that are still owed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 1 | Requested policy: 1 burst, 0 spread; adopted at a window boundary |
| req_ready | input | 1 | Controller accepts the current refresh request |
| req_valid | output | 1 | A refresh request is pending |
| req_row | output | $clog2(ROWS) | Row to refresh, stable while the request waits |
| busy | output | 1 | A burst pass is in progress |

## Verification
The bench times every event from the slot and window arithmetic.

- **Slot timing.** It checks that the first request appears exactly one slot after reset and not earlier. A design with an off-by-one slot counter fails this check.
- **Stalls and saturation.** It stalls the controller across three slots and then across twelve. Three slots must drain as exactly three refreshes, and twelve must drain as exactly eight. A design that drops owed refreshes or fails to saturate delivers the wrong count.
- **Policy changes.** It raises `mode_sel` in the middle of a window and expects spread refreshes to continue until the boundary. A design that switches early shows `busy` too soon or misses refreshes.
- **Interrupted burst.** It leaves a burst pass unfinished across a boundary while `mode_sel` asks for spread mode. Burst mode must be kept and the pass restarted, so exactly ROWS refreshes must follow. A design that ends the pass or changes policy mid-burst gives a different count or requests in spread mode.
- **Row order.** Every completed refresh is compared with an independently tracked row pointer, which catches a broken wrap.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    POLICY_SPREAD = 1'b0,
    POLICY_BURST  = 1'b1
  } refresh_policy_e;
endpackage

// File: rtl/refresh_timer.sv
// Slot and window tick generator for the refresh scheduler.
module refresh_timer #(
  parameter int SLOT_CYC = 31,
  parameter int ROWS     = 8
) (
  input  logic clk,
  input  logic rst,
  output logic slot_tick,
  output logic win_tick
);
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1;
  localparam int SW = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [CW-1:0] cyc_q;
  logic [SW-1:0] slot_q;

  assign slot_tick = (cyc_q == CW'(SLOT_CYC - 1));
  assign win_tick  = slot_tick && (slot_q == SW'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      slot_q <= '0;
    end else if (slot_tick) begin
      cyc_q  <= '0;
      slot_q <= (slot_q == SW'(ROWS - 1)) ? '0 : slot_q + 1'b1;
    end else begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  // R2: a slot end is a single-cycle pulse
  assert_slot_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    slot_tick |=> !slot_tick);
  // R6: a window boundary always falls on a slot end
  assert_window_on_slot_R6: assert property (@(posedge clk) disable iff (rst)
    win_tick |-> slot_tick);
endmodule

// File: rtl/refresh_pending.sv
// Tracks owed spread refreshes, the burst pass and the active policy.
module refresh_pending
  import refresh_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int OWE_MAX = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_sel,
  input  logic slot_tick,
  input  logic win_tick,
  input  logic done,
  output logic pending,
  output logic busy
);
  localparam int OW = $clog2(OWE_MAX + 1);
  localparam int BW = $clog2(ROWS + 1);

  refresh_policy_e policy_q, policy_n;
  logic [OW-1:0]   owed_q, owed_n;
  logic [BW-1:0]   left_q, left_n;
  logic            spread, enter_burst, inc, dec;

  assign spread      = (policy_q == POLICY_SPREAD);
  assign inc         = slot_tick && spread;
  assign dec         = done && spread;

  always_comb begin
    policy_n = policy_q;
    if (win_tick && (left_q == '0))
      policy_n = mode_sel ? POLICY_BURST : POLICY_SPREAD;
  end

  assign enter_burst = win_tick && (policy_n == POLICY_BURST);

  always_comb begin
    owed_n = owed_q;
    if (enter_burst)
      owed_n = '0;
    else if (inc && !dec)
      owed_n = (owed_q == OW'(OWE_MAX)) ? owed_q : owed_q + 1'b1;
    else if (dec && !inc)
      owed_n = owed_q - 1'b1;
  end

  always_comb begin
    left_n = left_q;
    if (enter_burst)
      left_n = BW'(ROWS);
    else if (done && !spread)
      left_n = left_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      policy_q <= POLICY_SPREAD;
      owed_q   <= '0;
      left_q   <= '0;
    end else begin
      policy_q <= policy_n;
      owed_q   <= owed_n;
      left_q   <= left_n;
    end
  end

  assign pending = spread ? (owed_q != '0) : (left_q != '0);
  assign busy    = (left_q != '0);

  // R5: the owed count never exceeds its depth
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    owed_q <= OW'(OWE_MAX));
  // R6: a pass only runs under the burst policy
  assert_busy_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (policy_q == POLICY_BURST));
  // R7: policy holds between window boundaries
  assert_policy_stable_R7: assert property (@(posedge clk) disable iff (rst)
    !win_tick |=> $stable(policy_q));
  // R8: an unfinished pass at a boundary restarts in burst mode
  assert_burst_restart_R8: assert property (@(posedge clk) disable iff (rst)
    (win_tick && busy) |=> (policy_q == POLICY_BURST) && (left_q == BW'(ROWS)));
endmodule

// File: rtl/row_refresh_sched.sv
// Top: periodic row refresh request generator with spread and burst policies.
module row_refresh_sched #(
  parameter int ROWS         = 8192,
  parameter int CLK_MHZ      = 250,
  parameter int RETENTION_US = 64000,
  parameter int OWE_MAX      = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mode_sel,
  input  logic                    req_ready,
  output logic                    req_valid,
  output logic [$clog2(ROWS)-1:0] req_row,
  output logic                    busy
);
  localparam int RW       = $clog2(ROWS);
  localparam int SLOT_CYC = (CLK_MHZ * RETENTION_US) / ROWS;

  logic slot_tick, win_tick, done;
  logic [RW-1:0] row_q;

  refresh_timer #(.SLOT_CYC(SLOT_CYC), .ROWS(ROWS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .slot_tick(slot_tick),
    .win_tick (win_tick)
  );

  refresh_pending #(.ROWS(ROWS), .OWE_MAX(OWE_MAX)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .slot_tick(slot_tick),
    .win_tick (win_tick),
    .done     (done),
    .pending  (req_valid),
    .busy     (busy)
  );

  assign done = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst)
      row_q <= '0;
    else if (done)
      row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
  end

  assign req_row = row_q;

  // R3: a waiting request holds its valid and its row
  assert_hold_request_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> req_valid && $stable(req_row));
  // R4: each completed refresh steps the row by one with wrap
  assert_row_step_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> (req_row == (($past(req_row) == RW'(ROWS - 1)) ? '0 : $past(req_row) + 1'b1)));
endmodule

// File: tb/row_refresh_sched_test.sv
`timescale 1ns/1ps
module row_refresh_sched_test;
  localparam int ROWS    = 8;
  localparam int CLK_MHZ = 250;
  localparam int RET_US  = 1;
  localparam int SLOT    = (CLK_MHZ * RET_US) / ROWS; // 31
  localparam int WIN     = SLOT * ROWS;               // 248

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_sel = 1'b0;
  logic req_ready = 1'b0;
  logic req_valid, busy;
  logic [2:0] req_row;

  int checks = 0;
  int fails = 0;
  int grants = 0;
  int cyc = 0;
  int exp_row = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  row_refresh_sched #(.ROWS(ROWS), .CLK_MHZ(CLK_MHZ), .RETENTION_US(RET_US), .OWE_MAX(8)) uut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_ready(req_ready),
    .req_valid(req_valid), .req_row(req_row), .busy(busy)
  );

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // R4: every completed refresh must carry the next row in ascending order
  always @(negedge clk) begin
    #1;
    if (!rst && req_valid && req_ready) begin
      check(int'(req_row) == exp_row, "R4 row order", int'(req_row), exp_row);
      exp_row = (exp_row + 1) % ROWS;
      grants++;
    end
  end

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(req_valid == 1'b0, "R1 valid in reset", req_valid, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(req_row == 3'd0, "R1 row in reset", req_row, 0);
    rst = 1'b0;
  endtask

  task automatic t_spread;
    wait_cyc(SLOT - 1);
    check(req_valid == 1'b0, "R2 no early request", req_valid, 0);
    wait_cyc(SLOT);
    check(req_valid == 1'b1, "R2 request after one slot", req_valid, 1);
    check(req_row == 3'd0, "R1 first row", req_row, 0);
    wait_cyc(40);
    check(req_valid && req_row == 3'd0, "R3 hold while stalled", req_row, 0);
    wait_cyc(2 * SLOT - 1);
    check(req_valid && req_row == 3'd0, "R3 hold across slot", req_row, 0);
    wait_cyc(3 * SLOT + 2);
    req_ready = 1'b1;
    wait_cyc(3 * SLOT + 7);
    check(grants == 3, "R5 three owed served", grants, 3);
    check(req_valid == 1'b0, "R5 drained", req_valid, 0);
    wait_cyc(4 * SLOT + 6);
    check(grants == 4, "R2 next slot refresh", grants, 4);
  endtask

  task automatic t_saturate;
    req_ready = 1'b0;
    wait_cyc(16 * SLOT + 4);
    check(req_valid == 1'b1, "R5 pending after stall", req_valid, 1);
    req_ready = 1'b1;
    wait_cyc(16 * SLOT + 19);
    check(grants == 12, "R5 saturated at eight", grants, 12);
    check(req_valid == 1'b0, "R5 saturated drain", req_valid, 0);
    check(req_row == 3'd4, "R4 wrap position", req_row, 4);
  endtask

  task automatic t_to_burst;
    mode_sel = 1'b1;
    wait_cyc(17 * SLOT + 8);
    check(busy == 1'b0, "R7 no mid-window switch", busy, 0);
    check(grants == 13, "R7 spread continues", grants, 13);
    wait_cyc(3 * WIN - 4);
    check(grants == 19, "R7 spread until boundary", grants, 19);
    wait_cyc(3 * WIN);
    check(busy == 1'b1, "R6 busy at boundary", busy, 1);
    check(req_valid == 1'b1, "R6 pass requests", req_valid, 1);
    wait_cyc(3 * WIN + 9);
    check(grants == 27, "R6 full pass", grants, 27);
    check(busy == 1'b0, "R6 busy ends", busy, 0);
    wait_cyc(800);
    check(req_valid == 1'b0, "R6 slot ignored in burst", req_valid, 0);
  endtask

  task automatic t_burst_hold;
    wait_cyc(900);
    req_ready = 1'b0;
    wait_cyc(4 * WIN);
    check(busy == 1'b1, "R6 second pass", busy, 1);
    mode_sel = 1'b0;
    wait_cyc(1100);
    req_ready = 1'b1;
    wait_cyc(1103);
    req_ready = 1'b0;
    check(grants == 30, "R3 partial pass", grants, 30);
    wait_cyc(5 * WIN + 1);
    check(busy == 1'b1, "R8 burst kept over boundary", busy, 1);
    wait_cyc(1250);
    req_ready = 1'b1;
    wait_cyc(1260);
    check(grants == 38, "R8 pass restarted in full", grants, 38);
    check(busy == 1'b0, "R8 pass done", busy, 0);
    wait_cyc(1280);
    check(req_valid == 1'b0, "R8 still burst policy", req_valid, 0);
    wait_cyc(6 * WIN + 12);
    check(req_valid == 1'b0 && busy == 1'b0, "R7 spread adopted", busy, 0);
    wait_cyc(49 * SLOT + 6);
    check(grants == 39, "R7 spread refresh resumes", grants, 39);
  endtask

  initial begin
    t_reset();
    t_spread();
    t_saturate();
    t_to_burst();
    t_burst_hold();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 1525);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule